// File: doc/BRIEF.md
# Hardware Semaphore Bank

This block holds a bank of one-bit hardware semaphores. Several processors share it so they can build mutual exclusion without atomic bus operations. Each semaphore is exposed as its own 32-bit word on a simple single-cycle register bus.

A bus read of a semaphore word is a complete test-and-set. The read returns the semaphore's previous value. If the semaphore was free, the read also marks it taken, so the reader now owns it. An owner gives the semaphore back by writing zero to the same word.

A status word tells software how many semaphores the bank holds. The count is fixed by a parameter and can be 32, 64, 128 or 256. The bus is combinational on the read side: `bus_rdata` is valid in the cycle the read strobe is high. Every state change lands on the rising clock edge that samples the strobe.

Top module: `hwsem_bank`

## Requirements
- R1: After reset every semaphore is free, so the first read of any semaphore word returns 0.
- R2: A read of a free semaphore returns 0 and leaves that semaphore taken, so the next read of it returns 1.
- R3: A read of a taken semaphore returns 1 and changes no semaphore.
- R4: A write of the value 0 to a semaphore word frees that semaphore.
- R5: A write of any nonzero value to a semaphore word has no effect: a taken semaphore stays taken, and a free one stays free.
- R6: Semaphore i answers at byte address 0x800 + 4*i, and an access to one semaphore leaves every other semaphore unchanged.
- R7: A read of byte address 0x14 returns the count code in bits 31:24 and zero in every other bit. The count code equals the semaphore count divided by 32 (1, 2, 4 or 8). This read changes no semaphore.
- R8: Unmapped addresses read as 0, and reads or writes to them change no semaphore. Unmapped addresses include byte addresses whose low two bits are not 00 and addresses past the last semaphore. While the read strobe is low, `bus_rdata` is 0.
- R9: A semaphore read returns the semaphore state in bit 0 and zero in bits 31:1.
- R10: When a read and a write of 0 hit the same semaphore in the same cycle, the read returns the old value and the semaphore ends free. A same-cycle nonzero write does not stop the read from taking the semaphore.
- R11: The read side effect happens once per clock edge that samples the read strobe. A read strobe held for two cycles on a free semaphore returns 0 and then 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe; a read of a semaphore word is a test-and-set |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; zero frees a semaphore |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |

## Verification
The bus can carry a read and a write at once, so acquire and release can target the same semaphore in one cycle. The bench raises both strobes together on one address, in three setups:
- a taken semaphore with write data 0;
- a free semaphore with write data 0;
- a free semaphore with nonzero write data.

In each case it compares the returned word against the pre-cycle state. A later read then shows whether the semaphore ended free or taken. Release must win in the first two setups, and the acquire must stand in the third.

// File: rtl/hwsem_pkg.sv
package hwsem_pkg;

  localparam int unsigned BUS_W       = 32;
  localparam int unsigned SEM_BASE    = 32'h0000_0800;
  localparam int unsigned STAT_OFS    = 32'h0000_0014;
  localparam int unsigned CODE_LSB    = 24;
  localparam int unsigned CODE_W      = 8;
  localparam int unsigned SEMS_PER_CODE = 32;

  // Count code published in the status word.
  function automatic logic [CODE_W-1:0] count_code(input int unsigned n);
    return CODE_W'(n / SEMS_PER_CODE);
  endfunction

  // Only the four power-of-two bank sizes are legal.
  function automatic bit count_legal(input int unsigned n);
    return (n == 32) || (n == 64) || (n == 128) || (n == 256);
  endfunction

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_SEM  = 2'd1,
    TGT_STAT = 2'd2
  } hwsem_tgt_e;

endpackage

// File: rtl/hwsem_rst_sync.sv
module hwsem_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/hwsem_decode.sv
module hwsem_decode
  import hwsem_pkg::*;
#(
  parameter int unsigned NUM_SEM = 32,
  parameter int unsigned ADDR_W  = 12,
  localparam int unsigned IDX_W  = $clog2(NUM_SEM)
) (
  input  logic [ADDR_W-1:0] addr,
  output hwsem_tgt_e        tgt,
  output logic [IDX_W-1:0]  sem_idx
);

  localparam int unsigned END_OFS = SEM_BASE + 4 * NUM_SEM;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(SEM_BASE);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(END_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  logic              aligned;
  logic              in_window;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    aligned   = (addr[1:0] == 2'b00);
    in_window = (addr >= BASE_A) && (addr < END_A);
    offset    = addr - BASE_A;
    sem_idx   = IDX_W'(offset >> 2);
    if (aligned && in_window) begin
      tgt = TGT_SEM;
    end else if (addr == STAT_A) begin
      tgt = TGT_STAT;
    end else begin
      tgt = TGT_NONE;
    end
  end

endmodule

// File: rtl/hwsem_cells.sv
module hwsem_cells #(
  parameter int unsigned NUM_SEM = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acq,
  input  logic               rel,
  input  logic [IDX_W-1:0]   sem_idx,
  output logic [NUM_SEM-1:0] sem_q
);

  logic [NUM_SEM-1:0] sem_d;
  logic [NUM_SEM-1:0] sem_en;

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
    logic sel;
    logic set_c;
    logic clr_c;

    always_comb begin
      sel      = (sem_idx == IDX_W'(g));
      set_c    = acq && sel;
      clr_c    = rel && sel;
      // Release outranks acquire when both land on this cell.
      sem_en[g] = set_c || clr_c;
      sem_d[g]  = clr_c ? 1'b0 : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sem_q[g] <= 1'b0;
      end else if (sem_en[g]) begin
        sem_q[g] <= sem_d[g];
      end
    end
  end

endmodule

// File: rtl/hwsem_rdmux.sv
module hwsem_rdmux
  import hwsem_pkg::*;
#(
  parameter int unsigned NUM_SEM = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               rd,
  input  hwsem_tgt_e         tgt,
  input  logic [IDX_W-1:0]   sem_idx,
  input  logic [NUM_SEM-1:0] sem_q,
  output logic [BUS_W-1:0]   rdata
);

  localparam logic [CODE_W-1:0] CODE = count_code(NUM_SEM);

  logic [BUS_W-1:0] stat_word;

  always_comb begin
    stat_word = '0;
    stat_word[CODE_LSB +: CODE_W] = CODE;
    rdata = '0;
    if (rd) begin
      unique case (tgt)
        TGT_SEM:  rdata = {{(BUS_W-1){1'b0}}, sem_q[sem_idx]};
        TGT_STAT: rdata = stat_word;
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/hwsem_bank.sv
module hwsem_bank
  import hwsem_pkg::*;
#(
  parameter int unsigned NUM_SEM = 32,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int unsigned IDX_W = $clog2(NUM_SEM);

  if (!count_legal(NUM_SEM)) begin : g_bad_count
    initial $error("hwsem_bank: NUM_SEM must be 32, 64, 128 or 256");
  end

  logic               rst_sync_n;
  hwsem_tgt_e         tgt;
  logic [IDX_W-1:0]   sem_idx;
  logic [NUM_SEM-1:0] sem_q;
  logic               acq;
  logic               rel;

  hwsem_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hwsem_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_decode (
    .addr    (bus_addr),
    .tgt     (tgt),
    .sem_idx (sem_idx)
  );

  always_comb begin
    acq = bus_rd && (tgt == TGT_SEM);
    rel = bus_wr && (tgt == TGT_SEM) && (bus_wdata == '0);
  end

  hwsem_cells #(.NUM_SEM(NUM_SEM)) u_cells (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .acq     (acq),
    .rel     (rel),
    .sem_idx (sem_idx),
    .sem_q   (sem_q)
  );

  hwsem_rdmux #(.NUM_SEM(NUM_SEM)) u_rdmux (
    .rd      (bus_rd),
    .tgt     (tgt),
    .sem_idx (sem_idx),
    .sem_q   (sem_q),
    .rdata   (bus_rdata)
  );

endmodule

// File: rtl/hwsem_bank_chk.sv
module hwsem_bank_chk
  import hwsem_pkg::*;
#(
  parameter int unsigned NUM_SEM = 32,
  parameter int unsigned ADDR_W  = 12
) (
  input logic               clk,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [NUM_SEM-1:0] sem_q
);

  localparam int unsigned IDX_W = $clog2(NUM_SEM);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(SEM_BASE);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(SEM_BASE + 4 * NUM_SEM);
  localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STAT_OFS);

  logic              hit;
  logic [ADDR_W-1:0] ofs;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    hit = (bus_addr[1:0] == 2'b00) && (bus_addr >= LO_A) && (bus_addr < HI_A);
    ofs = bus_addr - LO_A;
    idx = IDX_W'(ofs >> 2);
  end

  assert_take_free_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_rd && hit && (bus_rdata == 32'd0) && !(bus_wr && bus_wdata == 32'd0)
    |=> sem_q[$past(idx)]);

  assert_busy_stable_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_rd && hit && bus_rdata[0] && !bus_wr |=> $stable(sem_q));

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_wr && hit && (bus_wdata == 32'd0) |=> !sem_q[$past(idx)]);

  assert_nonzero_ignored_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_wr && !bus_rd && (bus_wdata != 32'd0) |=> $stable(sem_q));

  assert_status_word_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_rd && (bus_addr == ST_A) |-> bus_rdata == {count_code(NUM_SEM), 24'd0});

  assert_unmapped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd || bus_wr) && !hit |=> $stable(sem_q));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !bus_rd |-> bus_rdata == 32'd0);

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_rd && hit |-> bus_rdata[31:1] == 31'd0);

  assert_one_change_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    $countones(sem_q ^ $past(sem_q)) <= 1);

endmodule

bind hwsem_bank hwsem_bank_chk #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .sem_q     (sem_q)
);

// File: tb/hwsem_bank_tb.sv
module hwsem_bank_tb;

  localparam int unsigned NSEM = 64;
  localparam int unsigned AW   = 12;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_rd;
  logic          bus_wr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;

  int n_run;
  int n_fail;
  bit done;

  hwsem_bank #(.NUM_SEM(NSEM), .ADDR_W(AW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [AW-1:0] sem_addr(input int i);
    return AW'(32'h800 + 4 * i);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_rd = 1'b0; bus_wdata = v;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic do_rdwr(input logic [AW-1:0] a, input logic [31:0] v, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = v;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 begin bus_rd = 1'b0; bus_wr = 1'b0; end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    int bad;
    bad = 0;
    check("R8 idle rdata", bus_rdata, 32'd0);
    for (int i = 0; i < NSEM; i++) begin
      do_rd(sem_addr(i), d);
      if (d !== 32'd0) bad++;
    end
    check("R1 all free after reset", 32'(bad), 32'd0);
    for (int i = 0; i < NSEM; i++) do_wr(sem_addr(i), 32'd0);
  endtask

  task automatic t_acquire();
    logic [31:0] d;
    do_rd(sem_addr(5), d);  check("R2 first read free", d, 32'd0);
    do_rd(sem_addr(5), d);  check("R2 now taken", d, 32'd1);
    do_rd(sem_addr(5), d);  check("R3 taken stays taken", d, 32'd1);
  endtask

  task automatic t_release();
    logic [31:0] d;
    do_wr(sem_addr(5), 32'd0);
    do_rd(sem_addr(5), d);  check("R4 released", d, 32'd0);
  endtask

  task automatic t_nonzero();
    logic [31:0] d;
    do_rd(sem_addr(7), d);
    do_wr(sem_addr(7), 32'd1);
    do_wr(sem_addr(7), 32'hFFFF_FFFE);
    do_rd(sem_addr(7), d);  check("R5 nonzero write keeps taken", d, 32'd1);
    do_wr(sem_addr(8), 32'h8000_0001);
    do_rd(sem_addr(8), d);  check("R5 nonzero write does not set", d, 32'd0);
  endtask

  task automatic t_independent();
    logic [31:0] d;
    do_rd(sem_addr(0), d);
    do_rd(sem_addr(1), d);        check("R6 neighbour free", d, 32'd0);
    do_rd(sem_addr(NSEM-1), d);   check("R6 last lock free", d, 32'd0);
    do_rd(sem_addr(NSEM-1), d);   check("R6 last lock taken", d, 32'd1);
    do_wr(sem_addr(1), 32'd0);
    do_rd(sem_addr(0), d);        check("R6 other release leaves lock", d, 32'd1);
  endtask

  task automatic t_status();
    logic [31:0] d;
    do_rd(AW'(12'h014), d);   check("R7 status code", d, 32'h0200_0000);
    do_rd(AW'(12'h014), d);   check("R7 status repeat", d, 32'h0200_0000);
    do_rd(sem_addr(30), d);   check("R7 status read no side effect", d, 32'd0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    do_rd(sem_addr(NSEM), d);      check("R8 past last lock", d, 32'd0);
    do_rd(AW'(12'h805), d);        check("R8 misaligned read", d, 32'd0);
    do_rd(sem_addr(1), d);         check("R8 misaligned read no take", d, 32'd0);
    do_rd(sem_addr(2), d);
    do_wr(AW'(12'h809), 32'd0);
    do_rd(sem_addr(2), d);         check("R8 misaligned write no release", d, 32'd1);
    do_rd(AW'(12'h000), d);        check("R8 offset zero", d, 32'd0);
  endtask

  task automatic t_upper();
    logic [31:0] d;
    do_rd(sem_addr(40), d);  check("R9 free word", d, 32'd0);
    do_rd(sem_addr(40), d);  check("R9 taken word only bit0", d, 32'd1);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    do_rd(sem_addr(10), d);
    do_rdwr(sem_addr(10), 32'd0, d);   check("R10 taken: old value", d, 32'd1);
    do_rd(sem_addr(10), d);            check("R10 taken: ends free", d, 32'd0);
    do_rdwr(sem_addr(11), 32'd0, d);   check("R10 free: old value", d, 32'd0);
    do_rd(sem_addr(11), d);            check("R10 free: release wins", d, 32'd0);
    do_rdwr(sem_addr(12), 32'd3, d);   check("R10 nonzero: old value", d, 32'd0);
    do_rd(sem_addr(12), d);            check("R10 nonzero: acquire stands", d, 32'd1);
  endtask

  task automatic t_hold();
    logic [31:0] d1;
    logic [31:0] d2;
    @(negedge clk);
    bus_addr = sem_addr(20); bus_rd = 1'b1; bus_wr = 1'b0;
    #1 d1 = bus_rdata;
    @(negedge clk);
    #1 d2 = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
    check("R11 first cycle", d1, 32'd0);
    check("R11 second cycle", d2, 32'd1);
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_acquire();
    t_release();
    t_nonzero();
    t_independent();
    t_status();
    t_unmapped();
    t_upper();
    t_collision();
    t_hold();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule